// File: doc/BRIEF.md
# Redundant-Weight Successive-Approximation Controller

This block sequences one successive-approximation conversion and rebuilds its result. A `start` strobe opens a one-cycle sample window. The block then runs one comparison step per clock. It presents a trial code on `dac_code` and reads the external comparator's verdict on `cmp_in` at the end of that step's cycle. The step weights are a parameter array, ordered largest first. Their ratios are below two, so the converter takes more steps (`NSTEPS`) than it has output bits (`NBITS`). The overlap between search ranges lets a wrong early verdict be absorbed by later steps.

Each verdict is treated as a signed vote of +1 (input at or above the trial code) or −1. The trial code starts at mid-scale and moves up or down by the current weight. When the last verdict arrives, a separate fold stage forms the binary result from the stored votes: mid-scale, plus each signed vote times its weight, plus a final half-step term from the last verdict. The fold stage does not copy the trial register. The weight array must satisfy two conditions:

- each weight is at most one more than the sum of all smaller weights after it;
- all the weights together sum to exactly 2^(NBITS−1) − 1.

These conditions keep every trial code inside the `NBITS` range, and the block checks them when it is built.

The control is a four-state machine:

- **IDLE** waits. A high `start` moves it to **SAMPLE**; otherwise it stays in IDLE.
- **SAMPLE** always moves to **STEP** after one cycle.
- **STEP** repeats for step indices 0 to NSTEPS−1. On the last index it moves to **FINISH**.
- **FINISH** lasts one cycle and raises `done`. A high `start` there moves it straight to SAMPLE; otherwise it returns to IDLE.

Top module: `rsar_ctrl`

## Requirements
- R1: While reset is asserted and after it, the block is idle with `busy`=0, `done`=0, `dout`=0 and `dac_code` at mid-scale 2^(NBITS−1). Whenever `busy` is low, `dac_code` equals mid-scale.
- R2: A high `start` seen at a clock edge while idle (or in the done cycle) begins a conversion. `busy` is then high for exactly NSTEPS+1 cycles: one sample cycle, then one cycle per step.
- R3: `dac_code` is mid-scale in the sample cycle and in step 0. `cmp_in` is sampled at the end of each step's cycle, where 1 means the input is at or above the trial code. For steps k < NSTEPS−1, the next trial code is the current one plus weight k when `cmp_in` is 1 and minus weight k when it is 0. Weights are used in index order 0, 1, 2 and so on.
- R4: `done` is high for exactly one cycle, the cycle after the last step. In that cycle `busy` is low and `dac_code` is back at mid-scale. `dout` takes its new value in the same cycle and holds it until the next `done`.
- R5: `dout` = 2^(NBITS−1) + Σ_{k<NSTEPS−1}(2·d_k − 1)·w_k + d_{NSTEPS−1} − 1, where d_k is the verdict of step k. With a correct comparator this equals the input code, for every code from 0 to 2^NBITS − 1.
- R6: A verdict inverted at an early step still yields the input code, provided the residue after the error fits the later steps: |2·(vin − t_k) + 1| + 2·w_k ≤ 2·(sum of later weights) + 1, where t_k is the trial code at that step.
- R7: A `start` pulse during the sample cycle or any step is ignored. The conversion keeps its timing, its trial codes and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sample strobe that begins a conversion |
| cmp_in | input | 1 | Comparator verdict for the trial code shown in the current cycle |
| dac_code | output | NBITS | Trial code for the external DAC |
| busy | output | 1 | High during the sample cycle and all steps |
| done | output | 1 | One-cycle pulse when `dout` is updated |
| dout | output | NBITS | Corrected conversion result |

## Verification
The default 8-bit, 10-step weight set is tried with every input code and an honest comparator. This shows whether the fold and the trial path agree, and whether both reach the exact code at the range ends, where the search runs out of margin. Every code is then repeated with an inverted verdict at each of the first four steps, applied only where the residue bound allows. This separates a design that truly corrects errors from one that only echoes the final trial code. Start pulses placed in the sample cycle, mid-search and in the last step show whether a strobe in a busy cycle can restart or disturb the sequence.

// File: rtl/rsar_pkg.sv
package rsar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_STEP,
        ST_FINISH
    } rsar_state_e;

endpackage

// File: rtl/rsar_seq.sv
module rsar_seq
    import rsar_pkg::*;
#(
    parameter int NSTEPS = 10,
    localparam int IW = (NSTEPS > 2) ? $clog2(NSTEPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          step_en,
    output logic          last_step,
    output logic [IW-1:0] step_idx
);

    localparam logic [IW-1:0] LAST_IDX = IW'(NSTEPS - 1);

    rsar_state_e   state;
    rsar_state_e   state_nx;
    logic [IW-1:0] idx_nx;

    assign last_step = (step_idx == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step_idx <= '0;
        end else begin
            state    <= state_nx;
            step_idx <= idx_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        idx_nx   = step_idx;
        unique case (state)
            ST_IDLE, ST_FINISH: begin
                state_nx = start ? ST_SAMPLE : ST_IDLE;
                idx_nx   = '0;
            end
            ST_SAMPLE: begin
                state_nx = ST_STEP;
            end
            ST_STEP: begin
                if (last_step) begin
                    state_nx = ST_FINISH;
                end else begin
                    idx_nx = step_idx + 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        step_en = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_SAMPLE: busy = 1'b1;
            ST_STEP: begin
                busy    = 1'b1;
                step_en = 1'b1;
            end
            ST_FINISH: done = 1'b1;
        endcase
    end

    // busy-length counter for the checks below
    int busy_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= 0;
        end else begin
            busy_cnt <= busy ? busy_cnt + 1 : 0;
        end
    end

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == NSTEPS + 1));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(step_en && last_step)) |=> busy);

endmodule

// File: rtl/rsar_trial.sv
module rsar_trial #(
    parameter int          NBITS  = 8,
    parameter int          NSTEPS = 10,
    parameter int unsigned STEP_W [NSTEPS-1] = '{48, 28, 20, 12, 8, 5, 3, 2, 1},
    localparam int IW = (NSTEPS > 2) ? $clog2(NSTEPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             last_step,
    input  logic [IW-1:0]    step_idx,
    input  logic             cmp_in,
    output logic [NBITS-1:0] dac_code
);

    localparam logic [NBITS-1:0] MID = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0] wtab [NSTEPS];

    for (genvar i = 0; i < NSTEPS; i++) begin : g_wtab
        if (i < NSTEPS - 1) begin : g_real
            assign wtab[i] = NBITS'(STEP_W[i]);
        end else begin : g_tail
            assign wtab[i] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_code <= MID;
        end else if (step_en && !last_step) begin
            dac_code <= cmp_in ? dac_code + wtab[step_idx]
                               : dac_code - wtab[step_idx];
        end else begin
            dac_code <= MID;
        end
    end

    // R3
    up_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !last_step && cmp_in) |=> (dac_code > $past(dac_code)));

    // R3
    down_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !last_step && !cmp_in) |=> (dac_code < $past(dac_code)));

endmodule

// File: rtl/rsar_fold.sv
module rsar_fold #(
    parameter int          NBITS  = 8,
    parameter int          NSTEPS = 10,
    parameter int unsigned STEP_W [NSTEPS-1] = '{48, 28, 20, 12, 8, 5, 3, 2, 1},
    localparam int IW = (NSTEPS > 2) ? $clog2(NSTEPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             last_step,
    input  logic [IW-1:0]    step_idx,
    input  logic             cmp_in,
    output logic [NBITS-1:0] result
);

    localparam int SW = NBITS + 2;
    localparam logic [SW-1:0] MID_W = SW'(1) << (NBITS - 1);

    logic [NSTEPS-2:0] votes;
    logic [SW-1:0]     part [NSTEPS];
    logic [SW-1:0]     total;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            votes <= '0;
        end else if (step_en && !last_step) begin
            votes[step_idx] <= cmp_in;
        end
    end

    assign part[0] = MID_W;
    for (genvar i = 0; i < NSTEPS - 1; i++) begin : g_fold
        assign part[i+1] = votes[i] ? part[i] + SW'(STEP_W[i])
                                    : part[i] - SW'(STEP_W[i]);
    end

    // the last verdict arrives live and adds the half-step term
    assign total = part[NSTEPS-1] - {{(SW-1){1'b0}}, ~cmp_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (step_en && last_step) begin
            result <= total[NBITS-1:0];
        end
    end

endmodule

// File: rtl/rsar_ctrl.sv
module rsar_ctrl #(
    parameter int          NBITS  = 8,
    parameter int          NSTEPS = 10,
    parameter int unsigned STEP_W [NSTEPS-1] = '{48, 28, 20, 12, 8, 5, 3, 2, 1}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_in,
    output logic [NBITS-1:0] dac_code,
    output logic             busy,
    output logic             done,
    output logic [NBITS-1:0] dout
);

    localparam int IW  = (NSTEPS > 2) ? $clog2(NSTEPS) : 1;
    localparam int MID = 1 << (NBITS - 1);

    logic          step_en;
    logic          last_step;
    logic [IW-1:0] step_idx;

    rsar_seq #(.NSTEPS(NSTEPS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (busy),
        .done      (done),
        .step_en   (step_en),
        .last_step (last_step),
        .step_idx  (step_idx)
    );

    rsar_trial #(.NBITS(NBITS), .NSTEPS(NSTEPS), .STEP_W(STEP_W)) u_trial (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .last_step (last_step),
        .step_idx  (step_idx),
        .cmp_in    (cmp_in),
        .dac_code  (dac_code)
    );

    rsar_fold #(.NBITS(NBITS), .NSTEPS(NSTEPS), .STEP_W(STEP_W)) u_fold (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .last_step (last_step),
        .step_idx  (step_idx),
        .cmp_in    (cmp_in),
        .result    (dout)
    );

    // weight-set legality, evaluated once
    initial begin
        int  tail;
        bit  cover_ok;
        tail     = 0;
        cover_ok = 1'b1;
        for (int k = NSTEPS - 2; k >= 0; k--) begin
            if (STEP_W[k] < 1 || int'(STEP_W[k]) > tail + 1) cover_ok = 1'b0;
            tail += int'(STEP_W[k]);
        end
        // R6
        weight_cover_chk: assert (cover_ok)
            else $error("step weight exceeds later span plus one");
        // R5
        weight_span_chk: assert (tail == MID - 1)
            else $error("weight total %0d, needs %0d", tail, MID - 1);
    end

    // R1
    idle_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (int'(dac_code) == MID));

    // R5
    fold_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(dout) == int'($past(dac_code)) + int'($past(cmp_in)) - 1));

    // R4
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(dout));

endmodule

// File: tb/rsar_ctrl_tb.sv
`timescale 1ns/1ps
module rsar_ctrl_tb;

    localparam int          N   = 8;
    localparam int          M   = 10;
    localparam int unsigned W [M-1] = '{48, 28, 20, 12, 8, 5, 3, 2, 1};
    localparam int          MID = 1 << (N - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp_in = 1'b0;
    logic [N-1:0] dac_code;
    logic         busy;
    logic         done;
    logic [N-1:0] dout;

    int checks = 0;
    int errors = 0;
    int flips_applied = 0;

    always #2.5 clk = ~clk;

    rsar_ctrl #(.NBITS(N), .NSTEPS(M), .STEP_W(W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmp_in   (cmp_in),
        .dac_code (dac_code),
        .busy     (busy),
        .done     (done),
        .dout     (dout)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One conversion: starts and ends at a negedge.
    // flip_k: step whose verdict is inverted when recoverable (-1 none).
    // poke: step index at which a stray start is raised (-2 none, -1 sample cycle).
    task automatic convert(input int vin, input int flip_k, input int poke);
        int  t;
        int  res;
        int  rem;
        int  e2;
        bit  d;
        bit  flipped;
        flipped = 1'b0;
        res     = 0;
        start   = 1'b1;
        @(negedge clk);
        start = (poke == -1);
        chk(busy == 1'b1, "R2", "busy in sample", int'(busy), 1);
        chk(done == 1'b0, "R4", "done in sample", int'(done), 0);
        chk(int'(dac_code) == MID, "R3", "dac in sample", int'(dac_code), MID);
        t = MID;
        for (int k = 0; k < M; k++) begin
            @(negedge clk);
            start = (poke == k);
            chk(busy == 1'b1, (poke >= -1) ? "R7" : "R2", "busy in step",
                int'(busy), 1);
            chk(done == 1'b0, "R4", "done in step", int'(done), 0);
            chk(int'(dac_code) == t, (poke >= -1) ? "R7" : "R3", "trial code",
                int'(dac_code), t);
            d = (vin >= t);
            if (k == flip_k && k < M - 1) begin
                rem = 0;
                for (int j = k + 1; j < M - 1; j++) rem += int'(W[j]);
                e2 = 2 * (vin - t) + 1;
                if (e2 < 0) e2 = -e2;
                if (e2 + 2 * int'(W[k]) <= 2 * rem + 1) begin
                    d       = !d;
                    flipped = 1'b1;
                    flips_applied++;
                end
            end
            cmp_in = d;
            if (k < M - 1) t = d ? t + int'(W[k]) : t - int'(W[k]);
            else           res = t + int'(d) - 1;
        end
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R4", "done pulse", int'(done), 1);
        chk(busy == 1'b0, "R2", "busy after last step", int'(busy), 0);
        chk(int'(dac_code) == MID, "R4", "dac back to mid", int'(dac_code), MID);
        chk(int'(dout) == res, "R5", "signed-vote sum", int'(dout), res);
        chk(int'(dout) == vin, flipped ? "R6" : ((poke >= -1) ? "R7" : "R5"),
            "result vs input", int'(dout), vin);
        @(negedge clk);
        chk(done == 1'b0, "R4", "done one cycle", int'(done), 0);
        chk(busy == 1'b0, "R1", "idle busy", int'(busy), 0);
        chk(int'(dac_code) == MID, "R1", "idle dac", int'(dac_code), MID);
        chk(int'(dout) == vin, "R4", "dout held", int'(dout), vin);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
        chk(int'(dac_code) == MID, "R1", "dac in reset", int'(dac_code), MID);
        chk(int'(dout) == 0, "R1", "dout in reset", int'(dout), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(int'(dac_code) == MID, "R1", "dac after reset", int'(dac_code), MID);

        // full sweep, honest comparator (R5)
        for (int v = 0; v < (1 << N); v++) convert(v, -1, -2);

        // sweep with an inverted early verdict (R6)
        for (int fk = 0; fk < 4; fk++) begin
            for (int v = 0; v < (1 << N); v++) convert(v, fk, -2);
        end
        chk(flips_applied > 0, "R6", "flips applied", flips_applied, 1);

        // stray start pulses while busy (R7)
        convert(0, -1, -1);
        convert(200, -1, 0);
        convert(77, -1, 4);
        convert((1 << N) - 1, -1, M - 1);
        convert(MID, 1, 3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule